// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block is the decision logic that sits ahead of a telecom clock synthesizer. It keeps track of the loop's operating state: free-running, locked to the primary or the secondary reference, or in holdover on either one. It decodes two mode bits and a reference-select bit into that state. It also checks that the source feeding the chosen slot suits the framer mode (E1 or T1) and the configured loop frequency.

Each reference slot takes its source from a 3-bit selector. Changing references is a two-step operation. Software first writes a new source into the slot that is not in use. It then toggles the select bit, but only after a full frame has elapsed. The frame is measured with an external 125 µs frame-tick input.

The block reports three things: the state code, the index of the active source, and a flag for a rejected configuration. It also pulses a flag when a slot-to-slot move requires time-interval-error correction. A sticky bit records any select toggle that arrived too early.

Top module: `timing_ref_selector`

## Requirements
- R1: After reset, the outputs read as follows: `stateCode` = 0 (free-run), `activeSrc` = 7 (none), and `cfgInvalid`, `phaseCorrect` and `earlyToggleErr` all 0. Both slots hold source 6 (external sync), and the frame wait counts as already satisfied.
- R2: State codes are 0 free-run, 1 normal-primary, 2 normal-secondary, 3 holdover-primary and 4 holdover-secondary. Mode 00 selects normal and mode 01 selects holdover; in both, an accepted select of 0 picks primary and 1 picks secondary. Mode 10 selects free-run. A mode change shows at the outputs one clock later. `activeSrc` shows the in-use slot's source, or 7 in free-run.
- R3: Source codes are: 0 to 3 for line receive clocks, 4 for the backplane clock, 5 for the backplane frame pulse, 6 for external sync and 7 for none. Loop frequency codes are 00 = 2.048 MHz, 01 = 1.544 MHz and 10 = 8 kHz. The allowed sources are:
  - E1 (`isT1` = 0): at 00, codes 0 to 4 and 6; at 01, only 6; at 10, 5 and 6.
  - T1 (`isT1` = 1): at 00, 4 and 6; at 01, codes 0 to 3 and 6; at 10, 5 and 6.
  - Loop frequency 11 allows no source.
- R4: The configuration is invalid when the mode is 11, or when the target slot's source is not allowed. Free-run is always valid. On an invalid configuration, `cfgInvalid` reads 1 one clock later, and `stateCode` and `activeSrc` keep their values.
- R5: A selector change to a slot that is in use (normal or holdover on it) is ignored. In free-run both slots take changes. A slot's new source is latched on one clock and can drive the state from the next.
- R6: Outside free-run, a change written into the idle slot restarts the frame wait. A select toggle is accepted only once `frameTick` has been high on `FRAME_TICKS` clocks since that restart (default 2).
- R7: A select toggle outside free-run while the wait is incomplete is rejected. The accepted selection stays as it was, and `earlyToggleErr` goes to 1 and stays 1 until reset.
- R8: In free-run the select bit is taken immediately with no wait and no error. A later move to normal or holdover uses that selection.
- R9: `phaseCorrect` is a one-clock pulse. It fires when `tieEnable` is 1 and the state moves from one slot to the other, with both the old and new states outside free-run (normal or holdover).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-clock pulse per 125 µs frame |
| modeBits | input | 2 | 00 normal, 01 holdover, 10 free-run, 11 invalid |
| refSelect | input | 1 | Reference select: 0 primary, 1 secondary |
| tieEnable | input | 1 | Enables flagging of slot changes for TIE correction |
| isT1 | input | 1 | Framer mode: 0 E1, 1 T1 |
| loopFreq | input | 2 | Loop input frequency code |
| primSrc | input | 3 | Source selector for the primary slot |
| secSrc | input | 3 | Source selector for the secondary slot |
| stateCode | output | 3 | Registered loop state |
| activeSrc | output | 3 | Registered in-use source, 7 in free-run |
| cfgInvalid | output | 1 | Previous clock's configuration was rejected |
| phaseCorrect | output | 1 | Pulse: slot change needing TIE correction |
| earlyToggleErr | output | 1 | Sticky: a select toggle arrived before the wait ended |

## Verification
The assertions check several properties on every cycle:
- An in-use slot's latched source never moves.
- The error bit never clears.
- A rejected configuration never moves the state.
- A phase-correct pulse always coincides with a state change.
- A locked, valid state always names a source allowed by the previous cycle's frequency and framer mode.

Other properties show only in the bench's scenarios. These include:
- the frame-wait window, where a toggle is rejected before the ticks arrive and accepted after them;
- the free-run bypass of that window;
- the full compatibility table across E1 and T1;
- the latency from a selector write to its use.

The reference model, driven with mixed random stimulus, covers these as well.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  localparam int SRC_W = 3;

  localparam logic [SRC_W-1:0] SRC_BP_CLK   = 3'd4;
  localparam logic [SRC_W-1:0] SRC_BP_FRAME = 3'd5;
  localparam logic [SRC_W-1:0] SRC_EXT_SYNC = 3'd6;
  localparam logic [SRC_W-1:0] SRC_NONE     = 3'd7;

  typedef enum logic [2:0] {
    ST_FREE     = 3'd0,
    ST_NORM_PRI = 3'd1,
    ST_NORM_SEC = 3'd2,
    ST_HOLD_PRI = 3'd3,
    ST_HOLD_SEC = 3'd4
  } loopState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic             loadPri;
    logic             loadSec;
    logic             restartWait;
    logic             selNext;
    logic             flagEarly;
    logic             commit;
    loopState_e       nextState;
    logic [SRC_W-1:0] nextSrc;
    logic             invalid;
    logic             phaseHit;
  } ctrlStrobe_t;

  function automatic logic srcAllowed(input logic isT1, input logic [1:0] freq,
                                      input logic [SRC_W-1:0] src);
    logic ok;
    case ({isT1, freq})
      3'b000:  ok = (src != SRC_BP_FRAME) && (src != SRC_NONE);
      3'b001:  ok = (src == SRC_EXT_SYNC);
      3'b100:  ok = (src == SRC_BP_CLK) || (src == SRC_EXT_SYNC);
      3'b101:  ok = (src < SRC_BP_CLK) || (src == SRC_EXT_SYNC);
      3'b010,
      3'b110:  ok = (src == SRC_BP_FRAME) || (src == SRC_EXT_SYNC);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic onPrimary(input loopState_e s);
    return (s == ST_NORM_PRI) || (s == ST_HOLD_PRI);
  endfunction

  function automatic logic onSecondary(input loopState_e s);
    return (s == ST_NORM_SEC) || (s == ST_HOLD_SEC);
  endfunction

endpackage

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeBits,
  input  logic             refSelect,
  input  logic             tieEnable,
  input  logic             isT1,
  input  logic [1:0]       loopFreq,
  input  logic [SRC_W-1:0] primSrc,
  input  logic [SRC_W-1:0] secSrc,
  input  logic [SRC_W-1:0] priQ,
  input  logic [SRC_W-1:0] secQ,
  input  logic             waitDone,
  input  logic             selAccQ,
  input  logic             selPrevQ,
  input  loopState_e       stateQ,
  input  logic [SRC_W-1:0] activeSrcQ,
  input  logic             invalidQ,
  output ctrlStrobe_t      strobe
);

  logic priInUse, secInUse, locked;
  logic freeMode, toggled, selNext;
  loopState_e target;
  logic targetLegal, targetOnSec, cfgOk;
  logic [SRC_W-1:0] targetSrc;

  assign priInUse = onPrimary(stateQ);
  assign secInUse = onSecondary(stateQ);
  assign locked   = priInUse | secInUse;
  assign freeMode = (modeBits == 2'b10);
  assign toggled  = (refSelect != selPrevQ);

  always_comb begin
    if (freeMode)                 selNext = refSelect;
    else if (toggled && waitDone) selNext = refSelect;
    else                          selNext = selAccQ;
  end

  always_comb begin
    targetLegal = 1'b1;
    case (modeBits)
      2'b00:   target = selNext ? ST_NORM_SEC : ST_NORM_PRI;
      2'b01:   target = selNext ? ST_HOLD_SEC : ST_HOLD_PRI;
      2'b10:   target = ST_FREE;
      default: begin
        target      = stateQ;
        targetLegal = 1'b0;
      end
    endcase
  end

  assign targetSrc   = selNext ? secQ : priQ;
  assign targetOnSec = onSecondary(target);
  assign cfgOk = targetLegal &&
                 ((target == ST_FREE) || srcAllowed(isT1, loopFreq, targetSrc));

  always_comb begin
    strobe             = '0;
    strobe.loadPri     = (primSrc != priQ) && !priInUse;
    strobe.loadSec     = (secSrc != secQ) && !secInUse;
    strobe.restartWait = (strobe.loadPri && secInUse) || (strobe.loadSec && priInUse);
    strobe.selNext     = selNext;
    strobe.flagEarly   = !freeMode && toggled && !waitDone;
    strobe.commit      = cfgOk;
    strobe.nextState   = target;
    strobe.nextSrc     = (target == ST_FREE) ? SRC_NONE : targetSrc;
    strobe.invalid     = !cfgOk;
    strobe.phaseHit    = cfgOk && tieEnable && locked && (target != ST_FREE) &&
                         (targetOnSec != secInUse);
  end

  // R3: a valid locked state always uses a source allowed by last cycle's setup
  a_r3_source_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (!invalidQ && stateQ != ST_FREE) |-> srcAllowed($past(isT1), $past(loopFreq), activeSrcQ));

endmodule

// File: rtl/refsel_datapath.sv
module refsel_datapath
  import refsel_pkg::*;
#(
  parameter int FRAME_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTick,
  input  logic             refSelect,
  input  logic [SRC_W-1:0] primSrc,
  input  logic [SRC_W-1:0] secSrc,
  input  ctrlStrobe_t      strobe,
  output logic [SRC_W-1:0] priQ,
  output logic [SRC_W-1:0] secQ,
  output logic             waitDone,
  output logic             selAccQ,
  output logic             selPrevQ,
  output loopState_e       stateQ,
  output logic [SRC_W-1:0] activeSrcQ,
  output logic             invalidQ,
  output logic             phaseQ,
  output logic             earlyErrQ
);

  localparam int CNT_W = $clog2(FRAME_TICKS + 1);
  localparam logic [CNT_W-1:0] WAIT_FULL = CNT_W'(FRAME_TICKS);

  logic [CNT_W-1:0] waitCnt;

  assign waitDone = (waitCnt == WAIT_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priQ <= SRC_EXT_SYNC;
      secQ <= SRC_EXT_SYNC;
    end else begin
      if (strobe.loadPri) priQ <= primSrc;
      if (strobe.loadSec) secQ <= secSrc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          waitCnt <= WAIT_FULL;
    else if (strobe.restartWait)        waitCnt <= '0;
    else if (frameTick && !waitDone)    waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAccQ    <= 1'b0;
      selPrevQ   <= 1'b0;
      stateQ     <= ST_FREE;
      activeSrcQ <= SRC_NONE;
      invalidQ   <= 1'b0;
      phaseQ     <= 1'b0;
      earlyErrQ  <= 1'b0;
    end else begin
      selAccQ  <= strobe.selNext;
      selPrevQ <= refSelect;
      if (strobe.commit) begin
        stateQ     <= strobe.nextState;
        activeSrcQ <= strobe.nextSrc;
      end
      invalidQ <= strobe.invalid;
      phaseQ   <= strobe.phaseHit;
      if (strobe.flagEarly) earlyErrQ <= 1'b1;
    end
  end

  // R7: error bit never clears outside reset
  a_r7_sticky_error: assert property (@(posedge clk) disable iff (!rstN)
    earlyErrQ |=> earlyErrQ);

  // R5: in-use slot sources stay put
  a_r5_primary_held: assert property (@(posedge clk) disable iff (!rstN)
    onPrimary(stateQ) |=> $stable(priQ));
  a_r5_secondary_held: assert property (@(posedge clk) disable iff (!rstN)
    onSecondary(stateQ) |=> $stable(secQ));

  // R4: a rejected configuration leaves the state alone
  a_r4_state_kept: assert property (@(posedge clk) disable iff (!rstN)
    invalidQ |-> ($stable(stateQ) && $stable(activeSrcQ)));

  // R9: a correction pulse always accompanies a state change
  a_r9_phase_on_move: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ |-> (stateQ != $past(stateQ)));

  // R2: free-run reports no source
  a_r2_free_no_source: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FREE) |-> (activeSrcQ == SRC_NONE));

endmodule

// File: rtl/timing_ref_selector.sv
module timing_ref_selector
  import refsel_pkg::*;
#(
  parameter int FRAME_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic [1:0] modeBits,
  input  logic       refSelect,
  input  logic       tieEnable,
  input  logic       isT1,
  input  logic [1:0] loopFreq,
  input  logic [2:0] primSrc,
  input  logic [2:0] secSrc,
  output logic [2:0] stateCode,
  output logic [2:0] activeSrc,
  output logic       cfgInvalid,
  output logic       phaseCorrect,
  output logic       earlyToggleErr
);

  ctrlStrobe_t      strobe;
  logic [SRC_W-1:0] priQ, secQ, activeSrcQ;
  logic             waitDone, selAccQ, selPrevQ, invalidQ;
  loopState_e       stateQ;

  refsel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeBits   (modeBits),
    .refSelect  (refSelect),
    .tieEnable  (tieEnable),
    .isT1       (isT1),
    .loopFreq   (loopFreq),
    .primSrc    (primSrc),
    .secSrc     (secSrc),
    .priQ       (priQ),
    .secQ       (secQ),
    .waitDone   (waitDone),
    .selAccQ    (selAccQ),
    .selPrevQ   (selPrevQ),
    .stateQ     (stateQ),
    .activeSrcQ (activeSrcQ),
    .invalidQ   (invalidQ),
    .strobe     (strobe)
  );

  refsel_datapath #(.FRAME_TICKS(FRAME_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .frameTick  (frameTick),
    .refSelect  (refSelect),
    .primSrc    (primSrc),
    .secSrc     (secSrc),
    .strobe     (strobe),
    .priQ       (priQ),
    .secQ       (secQ),
    .waitDone   (waitDone),
    .selAccQ    (selAccQ),
    .selPrevQ   (selPrevQ),
    .stateQ     (stateQ),
    .activeSrcQ (activeSrcQ),
    .invalidQ   (invalidQ),
    .phaseQ     (phaseCorrect),
    .earlyErrQ  (earlyToggleErr)
  );

  assign stateCode  = stateQ;
  assign activeSrc  = activeSrcQ;
  assign cfgInvalid = invalidQ;

endmodule

// File: tb/tb_timing_ref_selector.sv
module tb_timing_ref_selector;

  localparam int FT = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameTick, refSelect, tieEnable, isT1;
  logic [1:0] modeBits, loopFreq;
  logic [2:0] primSrc, secSrc;
  logic [2:0] stateCode, activeSrc;
  logic       cfgInvalid, phaseCorrect, earlyToggleErr;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  timing_ref_selector #(.FRAME_TICKS(FT)) dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .modeBits(modeBits),
    .refSelect(refSelect), .tieEnable(tieEnable), .isT1(isT1), .loopFreq(loopFreq),
    .primSrc(primSrc), .secSrc(secSrc), .stateCode(stateCode), .activeSrc(activeSrc),
    .cfgInvalid(cfgInvalid), .phaseCorrect(phaseCorrect), .earlyToggleErr(earlyToggleErr)
  );

  // ---------------- behavioural reference model ----------------
  int mState = 0, mSrc = 7, mInv = 0, mPhase = 0, mErr = 0;
  int mPri = 6, mSec = 6, mWait = FT, mSelAcc = 0, mSelPrev = 0;

  function automatic bit allowedRef(int t1, int freq, int src);
    int mask;
    if (t1 == 0) mask = (freq == 0) ? 'h5F : (freq == 1) ? 'h40 : (freq == 2) ? 'h60 : 0;
    else         mask = (freq == 0) ? 'h50 : (freq == 1) ? 'h4F : (freq == 2) ? 'h60 : 0;
    return ((mask >> src) & 1) == 1;
  endfunction

  function automatic int slotOfState(int s);
    if (s == 1 || s == 3) return 0;
    if (s == 2 || s == 4) return 1;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mSrc = 7; mInv = 0; mPhase = 0; mErr = 0;
      mPri = 6; mSec = 6; mWait = FT; mSelAcc = 0; mSelPrev = 0;
    end else begin
      int inUse, tgt, tsrc, selN, errN, wN;
      bit priChg, secChg, restart, ok, ph;
      inUse   = slotOfState(mState);
      priChg  = (int'(primSrc) != mPri) && inUse != 0;
      secChg  = (int'(secSrc) != mSec) && inUse != 1;
      restart = (inUse == 1 && priChg) || (inUse == 0 && secChg);
      selN = mSelAcc; errN = mErr;
      if (modeBits == 2) selN = refSelect;
      else if (int'(refSelect) != mSelPrev) begin
        if (mWait >= FT) selN = refSelect; else errN = 1;
      end
      case (modeBits)
        0: tgt = selN ? 2 : 1;
        1: tgt = selN ? 4 : 3;
        2: tgt = 0;
        default: tgt = -1;
      endcase
      tsrc = selN ? mSec : mPri;
      ok = (tgt == 0) || (tgt > 0 && allowedRef(isT1, loopFreq, tsrc));
      ph = ok && tieEnable && mState != 0 && tgt > 0 && slotOfState(tgt) != inUse;
      if (ok) begin mState = tgt; mSrc = (tgt == 0) ? 7 : tsrc; end
      mInv = ok ? 0 : 1;
      mPhase = ph;
      if (priChg) mPri = primSrc;
      if (secChg) mSec = secSrc;
      wN = mWait;
      if (restart) wN = 0; else if (frameTick && mWait < FT) wN = mWait + 1;
      mWait = wN;
      mSelAcc = selN; mSelPrev = refSelect; mErr = errN;
    end
  end

  // model comparison on every clock (R2 outputs, plus the flags of R4 R7 R9)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (stateCode != mState[2:0] || activeSrc != mSrc[2:0] || cfgInvalid != mInv[0] ||
          phaseCorrect != mPhase[0] || earlyToggleErr != mErr[0]) begin
        fails++;
        $display("FAIL R2 model t=%0t actual st=%0d src=%0d inv=%0b ph=%0b err=%0b expected st=%0d src=%0d inv=%0d ph=%0d err=%0d",
                 $time, stateCode, activeSrc, cfgInvalid, phaseCorrect, earlyToggleErr,
                 mState, mSrc, mInv, mPhase, mErr);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    rstN = 0; frameTick = 0; refSelect = 0; tieEnable = 1; isT1 = 0;
    modeBits = 2'b10; loopFreq = 2'b00; primSrc = 3; secSrc = 6;
    step(4);
    rstN = 1;
    step(1);
    chk("R1 state", stateCode, 0);   chk("R1 src", activeSrc, 7);
    chk("R1 inv", cfgInvalid, 0);    chk("R1 phase", phaseCorrect, 0);
    chk("R1 err", earlyToggleErr, 0);
    step(1);
    modeBits = 2'b00; step(1);
    chk("R2 normal primary", stateCode, 1); chk("R2 src", activeSrc, 3);
    // R5: in-use selector change ignored
    primSrc = 0; step(3);
    chk("R5 in-use ignored", activeSrc, 3);
    primSrc = 3; step(1);
    // R8: free-run takes select with no wait
    secSrc = 1; step(1);
    modeBits = 2'b10; step(1);
    chk("R2 freerun state", stateCode, 0); chk("R2 freerun src", activeSrc, 7);
    refSelect = 1; step(1);
    chk("R8 no error", earlyToggleErr, 0);
    modeBits = 2'b00; step(1);
    chk("R8 secondary", stateCode, 2); chk("R8 src", activeSrc, 1);
    chk("R9 no pulse from freerun", phaseCorrect, 0);
    // R7: early toggle rejected
    refSelect = 0; step(1);
    chk("R7 err set", earlyToggleErr, 1); chk("R7 state kept", stateCode, 2);
    // R6: wait via frame ticks
    frameTick = 1; step(1); frameTick = 0; step(2);
    frameTick = 1; step(1); frameTick = 0; step(1);
    refSelect = 1; step(1);
    chk("R6 same slot", stateCode, 2);
    refSelect = 0; step(1);
    chk("R6 accepted", stateCode, 1); chk("R6 src", activeSrc, 3);
    chk("R9 pulse", phaseCorrect, 1);
    step(1);
    chk("R9 one cycle", phaseCorrect, 0); chk("R7 sticky", earlyToggleErr, 1);
    // holdover
    modeBits = 2'b01; step(1);
    chk("R2 holdover primary", stateCode, 3); chk("R9 no pulse same slot", phaseCorrect, 0);
    refSelect = 1; step(1);
    chk("R9 holdover move", stateCode, 4); chk("R9 holdover pulse", phaseCorrect, 1);
    // R4
    modeBits = 2'b11; step(1);
    chk("R4 mode11 inv", cfgInvalid, 1); chk("R4 state kept", stateCode, 4);
    modeBits = 2'b01; step(1);
    chk("R4 recovers", cfgInvalid, 0);
    // R3 table
    loopFreq = 2'b01; step(1);
    chk("R3 E1 1.544 line", cfgInvalid, 1); chk("R4 src kept", activeSrc, 1);
    isT1 = 1; step(1);
    chk("R3 T1 1.544 line", cfgInvalid, 0);
    loopFreq = 2'b10; step(1);
    chk("R3 T1 8k line", cfgInvalid, 1);
    loopFreq = 2'b00; step(1);
    chk("R3 T1 2.048 line", cfgInvalid, 1);
    modeBits = 2'b10; step(1);
    chk("R3 freerun valid", cfgInvalid, 0);
    secSrc = 4; step(1);
    modeBits = 2'b00; step(1);
    chk("R3 T1 2.048 bpclk", cfgInvalid, 0); chk("R3 src bpclk", activeSrc, 4);
    // mixed random stimulus compared against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 15);
      modeBits  = (r < 6) ? 2'b00 : (r < 11) ? 2'b01 : (r < 14) ? 2'b10 : 2'b11;
      frameTick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 4) == 0) refSelect = ~refSelect;
      if ($urandom_range(0, 6) == 0) primSrc = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 6) == 0) secSrc  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 20) == 0) loopFreq = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 20) == 0) isT1 = ~isT1;
      tieEnable = ($urandom_range(0, 3) != 0);
      step(1);
    end
    // R1 again after a mid-run reset
    rstN = 0; step(2); rstN = 1; modeBits = 2'b10; step(1);
    chk("R1 state after reset", stateCode, 0);
    chk("R1 err cleared", earlyToggleErr, 0);
    summary();
  end

endmodule